// File: doc/BRIEF.md
# Protected Configuration Register File

This block holds a 256-byte configuration space behind a simple one-request-per-cycle access port, such as the back end of a serial slave. A request is either a read or a write. It is aimed either at the volatile working space or at a non-volatile shadow copy. The shadow is modelled here as an internal array. Reads return one cycle later. Byte writes to the working space take effect at once. Writes to the shadow are gathered into a 16-byte page buffer, and the shadow is updated only when a whole page has arrived in order.

Four control registers at 0xE0..0xE3 sit outside the array. They hold the read and write protection modes, a sticky protect lock, soft-reload and erase controls, an erase page index, and a sticky error flag. Any write the block refuses sets the error flag. Two bytes mirror a live counter input and are read-only. The top page (0xF0..0xFF) holds factory service data that can be read but never changed. The slave-address byte at 0xC8 comes up as 0x01.

Top module: `protCfgRegs`

## Requirements
- R1: After rstN, rdValid is low. Working and shadow bytes hold their factory values: 0xC8 holds 0x01, each byte at 0xF0..0xFF holds 0xA5 XOR its address, and all others hold 0x00. All control fields and the error flag are 0.
- R2: A read request with reqValid=1 and reqWrite=0 raises rdValid with the data on rdData in the next cycle. A working-space byte write is visible to the next read.
- R3: Read mode is register 0xE0 bits [1:0]. Code 00 means unprotected. Code 01 makes reads of 0x00..0x7F return 0x00. Codes 10 and 11 make every array read (working or shadow) return 0x00. Reads of 0xE0..0xE3 in the working space are never protected.
- R4: Write mode is 0xE0 bits [3:2] and uses the same codes and address ranges. A blocked working write leaves the byte unchanged. A shadow page whose final beat lands in a blocked range is not committed. Both cases set the error flag. The reserved code 11 blocks all writes outside 0xE0..0xE3.
- R5: Writing 1 to 0xE1 bit 0 sets the lock, and only rstN clears it. While it is set, writes to 0xE0 are refused, the protection modes stay as they are, and the error flag is set.
- R6: Reading 0x7C returns liveCount[7:0] and reading 0x7D returns liveCount[15:8]. Working writes to these two addresses are dropped and set the error flag.
- R7: Writes to the service page 0xF0..0xFF are refused, whether to the working space, as a shadow page, or as an erase, and set the error flag. Its contents never change.
- R8: A shadow write (reqNvm=1) starts a page at offset 0. Each further beat must use the same page and the next offset. The shadow page changes only on the beat at offset 15. An out-of-order beat aborts the page and sets the error flag. A shadow read returns the shadow byte.
- R9: Writing 0xE1 with bit 1 set copies the whole shadow into the working space in one cycle. Lock, protection modes and the error flag are kept.
- R10: Writing 0xE1 with bit 2 set and bit 3 clear erases, to 0x00, the shadow page selected by 0xE2 bits [3:0]. With bits 2 and 3 set, it erases shadow pages 0..14. With bit 4 also set, nothing is erased and the error flag is set. Erasing page 15 sets the error flag. 0xE1 reads back bit 0 lock, bit 3 and bit 4 as last written.
- R11: The error flag is 0xE3 bit 0. A read of 0xE3 returns it and then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqNvm | input | 1 | 1 = target the shadow copy, 0 = the working space |
| reqAddr | input | 8 | Byte address |
| reqData | input | 8 | Write data |
| liveCount | input | 16 | Live counter value shown at 0x7C/0x7D |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| rdData | output | 8 | Read data |

## Verification
The bench goes after the places where protection codes, the lock and the page sequencer interact. A design that mis-decoded the partial mode would leak or block the wrong half. One that honoured the reserved code as "unprotected" would accept writes. One that let the lock slip would change 0xE0 after locking. On the page sequencer, the bench uses incomplete pages, out-of-order beats and pages in protected or service ranges. A sequencer that committed early or ignored order would change shadow bytes that a later shadow read shows unchanged. The bench also checks that reload copies the pre-erase shadow, that the chip-erase disable really blocks, and that reading the error flag clears it exactly once.

// File: rtl/protCfgPkg.sv
package protCfgPkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int OFS_W      = 4;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int CNT_W      = 2 * DATA_W;
  localparam int CTL_W      = 5;

  localparam logic [ADDR_W-1:0] ADR_PROT   = 8'hE0;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'hE1;
  localparam logic [ADDR_W-1:0] ADR_ERPG   = 8'hE2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 8'hE3;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 8'h7C;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 8'h7D;
  localparam logic [ADDR_W-1:0] ADR_SLAVE  = 8'hC8;
  localparam logic [DATA_W-1:0] SLAVE_RST  = 8'h01;
  localparam logic [DATA_W-1:0] SVC_SEED   = 8'hA5;

  // bit positions inside the control register
  localparam int B_LOCK   = 0;
  localparam int B_RELOAD = 1;
  localparam int B_ERASE  = 2;
  localparam int B_CHIP   = 3;
  localparam int B_NOCHIP = 4;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00, PROT_LOW = 2'b01, PROT_ALL = 2'b10, PROT_RSVD = 2'b11
  } protMode_e;

  typedef enum logic [2:0] {
    RD_ARR, RD_SHD, RD_CNT_LO, RD_CNT_HI, RD_CTRL, RD_ZERO
  } rdSel_e;

  typedef struct packed {
    logic              arrWr;
    logic              bufWr;
    logic              commit;
    logic              reload;
    logic              eraseGo;
    logic              eraseAll;
    logic [PAGE_W-1:0] erasePage;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [DATA_W-1:0] ctrlRd;
  } strobe_t;

  function automatic logic [DATA_W-1:0] factoryByte(input logic [ADDR_W-1:0] a);
    if (&a[ADDR_W-1:OFS_W]) return SVC_SEED ^ a;
    if (a == ADR_SLAVE)     return SLAVE_RST;
    return '0;
  endfunction
endpackage

// File: rtl/protCfgCtrl.sv
module protCfgCtrl
  import protCfgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqNvm,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CTL_W-1:0]  wrCtl,
  output strobe_t           stb
);
  protMode_e         rdModeQ, wrModeQ;
  logic              lockQ, chipSelQ, chipDisQ, errQ;
  logic [PAGE_W-1:0] erPageQ;
  logic              beatActQ;
  logic [OFS_W-1:0]  beatCntQ;
  logic [PAGE_W-1:0] beatPageQ;

  logic              isCtrl, isCnt, isSvc, rdBlk, wrBlk;
  logic              beatOk, lastBeat, errSet, errClr;
  logic [OFS_W-1:0]  offs;
  logic [PAGE_W-1:0] page;

  assign offs   = reqAddr[OFS_W-1:0];
  assign page   = reqAddr[ADDR_W-1:OFS_W];
  assign isCtrl = reqAddr[ADDR_W-1:2] == ADR_PROT[ADDR_W-1:2];
  assign isCnt  = (reqAddr == ADR_CNT_LO) || (reqAddr == ADR_CNT_HI);
  assign isSvc  = &page;
  assign rdBlk  = (rdModeQ == PROT_LOW) ? !reqAddr[ADDR_W-1] : rdModeQ[1];
  assign wrBlk  = (wrModeQ == PROT_LOW) ? !reqAddr[ADDR_W-1] : wrModeQ[1];
  assign beatOk = (offs == '0) ||
                  (beatActQ && page == beatPageQ && offs == beatCntQ);
  assign lastBeat = beatOk && (&offs);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ARR;
    errSet    = 1'b0;
    errClr    = 1'b0;
    if (reqValid) begin
      if (!reqWrite) begin
        stb.rdEn = 1'b1;
        if (reqNvm)                  stb.rdSel = rdBlk ? RD_ZERO : RD_SHD;
        else if (isCtrl) begin
          stb.rdSel = RD_CTRL;
          unique case (reqAddr[1:0])
            2'd0: stb.ctrlRd = {{(DATA_W-4){1'b0}}, wrModeQ, rdModeQ};
            2'd1: stb.ctrlRd = {{(DATA_W-5){1'b0}}, chipDisQ, chipSelQ, 2'b00, lockQ};
            2'd2: stb.ctrlRd = {{(DATA_W-PAGE_W){1'b0}}, erPageQ};
            default: begin
              stb.ctrlRd = {{(DATA_W-1){1'b0}}, errQ};
              errClr     = 1'b1;
            end
          endcase
        end
        else if (rdBlk)                 stb.rdSel = RD_ZERO;
        else if (reqAddr == ADR_CNT_LO) stb.rdSel = RD_CNT_LO;
        else if (reqAddr == ADR_CNT_HI) stb.rdSel = RD_CNT_HI;
        else                            stb.rdSel = RD_ARR;
      end else if (reqNvm) begin
        if (beatOk) begin
          stb.bufWr = 1'b1;
          if (lastBeat) begin
            if (isSvc || wrBlk) errSet = 1'b1;
            else                stb.commit = 1'b1;
          end
        end else errSet = 1'b1;
      end else if (isCtrl) begin
        if (reqAddr[1:0] == 2'd0 && lockQ) errSet = 1'b1;
        if (reqAddr[1:0] == 2'd1) begin
          stb.reload    = wrCtl[B_RELOAD];
          stb.erasePage = erPageQ;
          if (wrCtl[B_ERASE]) begin
            if (wrCtl[B_CHIP]) begin
              if (wrCtl[B_NOCHIP]) errSet = 1'b1;
              else begin
                stb.eraseGo  = 1'b1;
                stb.eraseAll = 1'b1;
              end
            end else if (&erPageQ) errSet = 1'b1;
            else stb.eraseGo = 1'b1;
          end
        end
      end else if (wrBlk || isCnt || isSvc) errSet = 1'b1;
      else stb.arrWr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdModeQ   <= PROT_NONE;
      wrModeQ   <= PROT_NONE;
      lockQ     <= 1'b0;
      chipSelQ  <= 1'b0;
      chipDisQ  <= 1'b0;
      erPageQ   <= '0;
      errQ      <= 1'b0;
      beatActQ  <= 1'b0;
      beatCntQ  <= '0;
      beatPageQ <= '0;
    end else begin
      if (reqValid && reqWrite && !reqNvm && isCtrl) begin
        case (reqAddr[1:0])
          2'd0: if (!lockQ) begin
            rdModeQ <= protMode_e'(wrCtl[1:0]);
            wrModeQ <= protMode_e'(wrCtl[3:2]);
          end
          2'd1: begin
            lockQ    <= lockQ | wrCtl[B_LOCK];
            chipSelQ <= wrCtl[B_CHIP];
            chipDisQ <= wrCtl[B_NOCHIP];
          end
          2'd2: erPageQ <= wrCtl[PAGE_W-1:0];
          default: ;
        endcase
      end
      if (reqValid && reqWrite && reqNvm) begin
        if (beatOk && !lastBeat) begin
          beatActQ  <= 1'b1;
          beatCntQ  <= offs + 1'b1;
          beatPageQ <= page;
        end else beatActQ <= 1'b0;
      end
      if (errSet)      errQ <= 1'b1;
      else if (errClr) errQ <= 1'b0;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ); // R5
  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable({rdModeQ, wrModeQ})); // R5
  AST_NO_CNT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.arrWr |-> !(reqAddr == ADR_CNT_LO || reqAddr == ADR_CNT_HI)); // R6
  AST_NO_SVC_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.arrWr || stb.commit) |-> !(&reqAddr[ADDR_W-1:OFS_W])); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !reqNvm && reqAddr == ADR_STAT) |=> !errQ); // R11
endmodule

// File: rtl/protCfgData.sv
module protCfgData
  import protCfgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] workMem [DEPTH];
  logic [DATA_W-1:0] shdMem  [DEPTH];
  logic [DATA_W-1:0] pgBuf   [PAGE_BYTES];
  logic [PAGE_BYTES*DATA_W-1:0] svcView;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSvc
    assign svcView[g*DATA_W +: DATA_W] = shdMem[DEPTH-PAGE_BYTES+g];
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) pgBuf[reqAddr[OFS_W-1:0]] <= reqData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        workMem[i] <= factoryByte(ADDR_W'(i));
        shdMem[i]  <= factoryByte(ADDR_W'(i));
      end
    end else begin
      if (stb.arrWr) workMem[reqAddr] <= reqData;
      if (stb.reload)
        for (int i = 0; i < DEPTH; i++) workMem[i] <= shdMem[i];
      if (stb.commit)
        for (int j = 0; j < PAGE_BYTES; j++)
          shdMem[{reqAddr[ADDR_W-1:OFS_W], OFS_W'(j)}] <=
            (j == PAGE_BYTES-1) ? reqData : pgBuf[j];
      if (stb.eraseGo)
        for (int i = 0; i < DEPTH - PAGE_BYTES; i++)
          if (stb.eraseAll || ADDR_W'(i) >> OFS_W == ADDR_W'(stb.erasePage))
            shdMem[i] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) begin
        unique case (stb.rdSel)
          RD_ARR:    rdData <= workMem[reqAddr];
          RD_SHD:    rdData <= shdMem[reqAddr];
          RD_CNT_LO: rdData <= liveCount[DATA_W-1:0];
          RD_CNT_HI: rdData <= liveCount[CNT_W-1:DATA_W];
          RD_CTRL:   rdData <= stb.ctrlRd;
          default:   rdData <= '0;
        endcase
      end
    end
  end

  AST_RD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> rdValid); // R2
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == RD_ZERO) |=> rdData == '0); // R3
  AST_SVC_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(svcView)); // R7
endmodule

// File: rtl/protCfgRegs.sv
module protCfgRegs
  import protCfgPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqNvm,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [CNT_W-1:0]  liveCount,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  strobe_t stb;

  protCfgCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqNvm   (reqNvm),
    .reqAddr  (reqAddr),
    .wrCtl    (reqData[CTL_W-1:0]),
    .stb      (stb)
  );

  protCfgData uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .liveCount (liveCount),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );
endmodule

// File: tb/sim_protCfgRegs.sv
module sim_protCfgRegs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqNvm = 1'b0;
  logic [7:0] reqAddr = '0, reqData = '0;
  logic [15:0] liveCount = '0;
  logic rdValid;
  logic [7:0] rdData;

  int tests = 0, fails = 0;
  string curReq = "R1";

  // behavioural reference state
  byte unsigned mMem[256], mShd[256], mBuf[16];
  bit [1:0] mRp, mWp;
  bit mLock, mChip, mDis, mErr, mAct;
  bit [3:0] mPg;
  int mCnt, mPage;

  always #(CLK_PERIOD/2) clk = ~clk;

  protCfgRegs u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqNvm(reqNvm), .reqAddr(reqAddr), .reqData(reqData),
    .liveCount(liveCount), .rdValid(rdValid), .rdData(rdData)
  );

  function automatic byte unsigned fac(int a);
    if (a >= 240) return 8'hA5 ^ a[7:0];
    if (a == 200) return 8'h01;
    return 8'h00;
  endfunction

  function automatic bit blk(bit [1:0] m, int a);
    if (m == 2'b01) return a < 128;
    return m[1];
  endfunction

  task automatic modelInit();
    for (int i = 0; i < 256; i++) begin
      mMem[i] = fac(i);
      mShd[i] = fac(i);
    end
    mRp = 0; mWp = 0; mLock = 0; mChip = 0; mDis = 0; mErr = 0;
    mAct = 0; mPg = 0; mCnt = 0; mPage = 0;
  endtask

  task automatic model(input bit v, w, n, input int a, input byte unsigned d,
                       output bit eV, output byte unsigned eD);
    int off, pg;
    eV = v && !w;
    eD = 0;
    if (!v) return;
    off = a % 16;
    pg  = a / 16;
    if (!w) begin
      if (n) eD = blk(mRp, a) ? 8'h00 : mShd[a];
      else if (a >= 224 && a <= 227) begin
        case (a)
          224: eD = {4'b0, mWp, mRp};
          225: eD = {3'b0, mDis, mChip, 2'b00, mLock};
          226: eD = {4'b0, mPg};
          default: begin eD = {7'b0, mErr}; mErr = 0; end
        endcase
      end
      else if (blk(mRp, a)) eD = 0;
      else if (a == 124) eD = liveCount[7:0];
      else if (a == 125) eD = liveCount[15:8];
      else eD = mMem[a];
    end else if (n) begin
      if (off == 0 || (mAct && pg == mPage && off == mCnt)) begin
        mBuf[off] = d;
        if (off == 15) begin
          mAct = 0;
          if (pg == 15 || blk(mWp, a)) mErr = 1;
          else for (int j = 0; j < 16; j++) mShd[pg*16+j] = mBuf[j];
        end else begin
          mAct = 1; mCnt = off + 1; mPage = pg;
        end
      end else begin
        mAct = 0; mErr = 1;
      end
    end else if (a == 224) begin
      if (mLock) mErr = 1;
      else begin mRp = d[1:0]; mWp = d[3:2]; end
    end else if (a == 225) begin
      if (d[1]) for (int i = 0; i < 256; i++) mMem[i] = mShd[i];
      mLock = mLock | d[0]; mChip = d[3]; mDis = d[4];
      if (d[2]) begin
        if (d[3]) begin
          if (d[4]) mErr = 1;
          else for (int i = 0; i < 240; i++) mShd[i] = 0;
        end else if (mPg == 15) mErr = 1;
        else for (int i = 0; i < 16; i++) mShd[mPg*16+i] = 0;
      end
    end else if (a == 226) mPg = d[3:0];
    else if (a == 227) ;
    else if (blk(mWp, a) || a == 124 || a == 125 || a >= 240) mErr = 1;
    else mMem[a] = d;
  endtask

  // one request per cycle; output compared with the model on every clock
  task automatic step(input bit v, w, n, input int a, input int d);
    bit eV;
    byte unsigned eD;
    reqValid = v; reqWrite = w; reqNvm = n;
    reqAddr = a[7:0]; reqData = d[7:0];
    model(v, w, n, a, d[7:0], eV, eD);
    @(negedge clk);
    tests++;
    if (rdValid !== eV || (eV && rdData !== eD)) begin
      fails++;
      $display("FAIL %s addr=%02h actual v=%b d=%02h expected v=%b d=%02h",
               curReq, a[7:0], rdValid, rdData, eV, eD);
    end
  endtask

  task automatic wr(int a, int d);  step(1, 1, 0, a, d); endtask
  task automatic rd(int a);         step(1, 0, 0, a, 0); endtask
  task automatic nwr(int a, int d); step(1, 1, 1, a, d); endtask
  task automatic nrd(int a);        step(1, 0, 1, a, 0); endtask
  task automatic idle();            step(0, 0, 0, 0, 0); endtask

  task automatic nvmPage(int pg, int base, int count);
    for (int j = 0; j < count; j++) nwr(pg*16 + j, base + j);
  endtask

  task automatic hardReset();
    rstN = 0; reqValid = 0; reqWrite = 0; reqNvm = 0;
    modelInit();
    repeat (3) @(negedge clk);
    tests++;
    if (rdValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rdValid in reset actual %b expected 0", rdValid);
    end
    rstN = 1;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    curReq = "R1";
    hardReset();
    rd(200); rd(0); rd(85); rd(224); rd(225); rd(227); rd(243);

    curReq = "R2";
    wr(16, 8'h3C); rd(16); wr(128, 8'h77); rd(128); idle();

    curReq = "R6";
    liveCount = 16'hBEEF;
    rd(124); rd(125); wr(124, 8'h11); rd(124);
    curReq = "R11";
    rd(227); rd(227);

    curReq = "R7";
    wr(245, 8'h00); rd(245); rd(227);

    curReq = "R8";
    nvmPage(2, 8'h20, 16); nrd(37); rd(37);
    nvmPage(3, 8'h30, 5); nrd(49); rd(227);
    nwr(55, 8'h99); rd(227); nrd(55);
    nvmPage(15, 8'h00, 16); rd(227); nrd(255);

    curReq = "R9";
    wr(225, 8'h02); rd(37); rd(16); rd(225);

    curReq = "R3";
    wr(144, 8'h12); rd(144);
    wr(224, 8'h01); rd(37); rd(144); rd(124);
    wr(224, 8'h02); rd(144); rd(224); nrd(37);
    wr(224, 8'h03); rd(144); rd(200);
    wr(224, 8'h00); rd(144);

    curReq = "R4";
    wr(224, 8'h04); wr(17, 8'h55); rd(17); rd(227); wr(145, 8'h66); rd(145);
    nvmPage(1, 8'h40, 16); rd(227); nrd(21);
    wr(224, 8'h0C); wr(146, 8'h01); rd(146); rd(227);
    wr(224, 8'h08); wr(147, 8'h02); rd(147); rd(227);
    wr(224, 8'h00);

    curReq = "R10";
    wr(226, 2); wr(225, 8'h04); nrd(37); rd(227);
    nvmPage(4, 8'h50, 16); nrd(69);
    wr(225, 8'h1C); rd(227); nrd(69); rd(225);
    wr(225, 8'h0C); nrd(69); nrd(200); nrd(240);
    wr(226, 15); wr(225, 8'h04); rd(227); nrd(250);

    curReq = "R5";
    wr(225, 8'h01); rd(225);
    wr(224, 8'h0F); rd(224); rd(227);
    wr(225, 8'h00); rd(225);
    wr(17, 8'hA1); rd(17);

    curReq = "R1";
    hardReset();
    rd(225); rd(17); rd(200);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule